// File: doc/BRIEF.md
# External Data Bus Decoder with Programmable Stretch

This block sits between an 8-bit microcontroller core and three on-chip data memories on the external data bus. The core raises a one-cycle request that carries a direction, one of two address forms and write data. In the pointer form the full 16-bit address arrives on one port. In the register-indirect form the low byte comes from the register operand and the high byte from a separate page register. The block builds the 16-bit address, finds which memory window it falls in, and drives a one-hot select with a window-relative offset.

The core is held with a wait signal while the access runs. The hold length is set by two values: a 3-bit stretch field from a clock-control register, sampled when the request is accepted, and a fixed wait count that belongs to the target window (six for the configuration window, zero for the others). Addresses outside the three windows select nothing. Reads from them return 0xFF and writes to them are dropped.

The sequencer has three states. ST_IDLE moves to ST_ACCESS on an accepted request (ACCEPT). ST_ACCESS stays in place while hold cycles remain (STRETCH) and moves to ST_DONE when the count is spent (RELEASE). ST_DONE always returns to ST_IDLE (RETIRE). Requests are only taken in ST_IDLE.

Top module: `xdata_stretch_ctrl`

## Requirements
- R1: The access address is `req_ptr` when `req_indirect` is 0, and {`page_hi`, `req_lo`} (page register in bits 15:8) when `req_indirect` is 1.
- R2: Addresses 0x0000 to 0x07FF select `mem_sel[0]` (general data RAM) with `mem_addr` equal to address bits 10:0, and add no fixed wait.
- R3: Addresses 0x1000 to 0x11FF select `mem_sel[1]` (configuration RAM) with `mem_addr` equal to the address minus 0x1000, and carry a fixed wait of 6.
- R4: Addresses 0x2000 to 0x20FF select `mem_sel[2]` (I/O register RAM) with `mem_addr` equal to the address minus 0x2000, and add no fixed wait.
- R5: `core_wait` rises in the cycle after the accepting clock edge and stays high for exactly 1 + max(S, F) consecutive cycles, where S is `stretch_sel` and F is the window's fixed wait (0 when unmapped).
- R6: A stretch value of 7 gives the longest access: 8 wait cycles in any window.
- R7: The stretch value, address and data are captured at acceptance. Changing `stretch_sel` or the request inputs during an access does not change its length, select or offset.
- R8: During a mapped access exactly one bit of `mem_sel` is high for every wait cycle. `mem_sel` is zero whenever `core_wait` is low.
- R9: For a mapped write, `mem_we` is high for exactly one cycle, the last cycle of `core_wait`, with `mem_wdata` equal to the request data.
- R10: For a read, `rd_valid` is high for one cycle, the first cycle after `core_wait` falls. `rd_data` holds the selected memory's byte at the access offset, registered at the end of the last wait cycle.
- R11: An unmapped access asserts no `mem_sel` and no `mem_we`, waits 1 + S cycles, and a read returns `rd_data` = 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request, taken in ST_IDLE |
| req_write | input | 1 | 1 = write, 0 = read |
| req_indirect | input | 1 | 1 = register-indirect form, 0 = pointer form |
| req_ptr | input | 16 | Full address for the pointer form |
| req_lo | input | 8 | Low address byte for the indirect form |
| page_hi | input | 8 | High address byte for the indirect form |
| req_wdata | input | 8 | Write data |
| stretch_sel | input | 3 | Stretch field from the clock-control register |
| core_wait | output | 1 | Holds the core while the access runs |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 8 | Registered read data |
| mem_sel | output | 3 | One-hot memory select: [0] data, [1] config, [2] I/O |
| mem_addr | output | 11 | Window-relative byte offset |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data to memory |
| mem_rdata | input | 24 | Read bytes: [7:0] data, [15:8] config, [23:16] I/O |

## Verification
Accesses are sent to each window through both address forms. Indirect requests carry a pointer-form value that points elsewhere, so a swapped address source sends the access to the wrong window. Stretch values of 0, 2, 3 and 7 are used against windows with and without the fixed wait, so the hold length shows whether the design takes the maximum, the sum, or only one of the two terms. The first and last byte of every window and the bytes just outside them are used to check the range compares. Writes followed by reads, unmapped writes, and stretch changes during an access show whether data lands, whether dropped writes stay dropped, and whether the captured stretch value is kept.

// File: rtl/xdw_pkg.sv
package xdw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_DONE   = 2'd2
    } xdw_state_e;

    localparam logic [7:0] XDW_EMPTY_BYTE = 8'hFF;

endpackage

// File: rtl/xdw_addr_former.sv
module xdw_addr_former #(
    parameter int unsigned BW = 8,
    localparam int unsigned AW = 2 * BW
) (
    input  logic          indirect,
    input  logic [AW-1:0] ptr,
    input  logic [BW-1:0] lo,
    input  logic [BW-1:0] hi,
    output logic [AW-1:0] addr
);

    always_comb begin
        if (indirect) begin
            addr = {hi, lo};
        end else begin
            addr = ptr;
        end
    end

endmodule

// File: rtl/xdw_region_decode.sv
module xdw_region_decode #(
    parameter int unsigned NREG   = 3,
    parameter int unsigned AW     = 16,
    parameter int unsigned OFS_W  = 11,
    parameter int unsigned WAIT_W = 4,
    parameter logic [NREG-1:0][AW-1:0]     BASE       = {16'h2000, 16'h1000, 16'h0000},
    parameter logic [NREG-1:0][4:0]        SPAN_LOG2  = {5'd8, 5'd9, 5'd11},
    parameter logic [NREG-1:0][WAIT_W-1:0] FIXED_WAIT = {4'd0, 4'd6, 4'd0}
) (
    input  logic [AW-1:0]     addr,
    output logic [NREG-1:0]   hit,
    output logic [OFS_W-1:0]  offset,
    output logic [WAIT_W-1:0] fixed_wait
);

    logic [NREG-1:0][OFS_W-1:0] ofs_each;

    for (genvar g = 0; g < NREG; g++) begin : g_win
        localparam logic [AW-1:0] LOW_MASK = (AW'(1) << SPAN_LOG2[g]) - AW'(1);
        assign hit[g]      = ((addr & ~LOW_MASK) == (BASE[g] & ~LOW_MASK));
        assign ofs_each[g] = OFS_W'(addr & LOW_MASK);
    end

    always_comb begin
        offset     = '0;
        fixed_wait = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) begin
                offset     = offset | ofs_each[i];
                fixed_wait = fixed_wait | FIXED_WAIT[i];
            end
        end
    end

endmodule

// File: rtl/xdw_hold_timer.sv
module xdw_hold_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             last
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && (cnt != '0)) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign last = (cnt == '0);

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !last) |=> (cnt == $past(cnt) - CNT_W'(1))); // R5

    AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (last == ($past(load_val) == '0))); // R7

endmodule

// File: rtl/xdata_stretch_ctrl.sv
module xdata_stretch_ctrl
    import xdw_pkg::*;
#(
    parameter int unsigned NREG      = 3,
    parameter int unsigned BW        = 8,
    parameter int unsigned OFS_W     = 11,
    parameter int unsigned STRETCH_W = 3,
    parameter int unsigned WAIT_W    = 4,
    localparam int unsigned AW       = 2 * BW,
    localparam int unsigned CNT_W    = (STRETCH_W > WAIT_W) ? STRETCH_W : WAIT_W,
    parameter logic [NREG-1:0][AW-1:0]     REGION_BASE = {16'h2000, 16'h1000, 16'h0000},
    parameter logic [NREG-1:0][4:0]        REGION_LOG2 = {5'd8, 5'd9, 5'd11},
    parameter logic [NREG-1:0][WAIT_W-1:0] REGION_WAIT = {4'd0, 4'd6, 4'd0}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_indirect,
    input  logic [AW-1:0]        req_ptr,
    input  logic [BW-1:0]        req_lo,
    input  logic [BW-1:0]        page_hi,
    input  logic [BW-1:0]        req_wdata,
    input  logic [STRETCH_W-1:0] stretch_sel,
    output logic                 core_wait,
    output logic                 rd_valid,
    output logic [BW-1:0]        rd_data,
    output logic [NREG-1:0]      mem_sel,
    output logic [OFS_W-1:0]     mem_addr,
    output logic                 mem_we,
    output logic [BW-1:0]        mem_wdata,
    input  logic [NREG*BW-1:0]   mem_rdata
);

    xdw_state_e state, state_nx;

    logic [AW-1:0]     full_addr;
    logic [NREG-1:0]   win_hit;
    logic [OFS_W-1:0]  win_ofs;
    logic [WAIT_W-1:0] win_wait;
    logic [CNT_W-1:0]  hold_val;
    logic              accept;
    logic              hold_last;

    logic              wr_q;
    logic [NREG-1:0]   sel_q;
    logic [BW-1:0]     rd_pick;

    xdw_addr_former #(.BW(BW)) u_form (
        .indirect (req_indirect),
        .ptr      (req_ptr),
        .lo       (req_lo),
        .hi       (page_hi),
        .addr     (full_addr)
    );

    xdw_region_decode #(
        .NREG       (NREG),
        .AW         (AW),
        .OFS_W      (OFS_W),
        .WAIT_W     (WAIT_W),
        .BASE       (REGION_BASE),
        .SPAN_LOG2  (REGION_LOG2),
        .FIXED_WAIT (REGION_WAIT)
    ) u_dec (
        .addr       (full_addr),
        .hit        (win_hit),
        .offset     (win_ofs),
        .fixed_wait (win_wait)
    );

    // hold length beyond the base cycle: larger of stretch and fixed wait
    always_comb begin
        if (CNT_W'(stretch_sel) > CNT_W'(win_wait)) begin
            hold_val = CNT_W'(stretch_sel);
        end else begin
            hold_val = CNT_W'(win_wait);
        end
    end

    assign accept = (state == ST_IDLE) && req_valid;

    xdw_hold_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (hold_val),
        .run      (state == ST_ACCESS),
        .last     (hold_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = ST_ACCESS;   // ACCEPT
            ST_ACCESS: if (hold_last) state_nx = ST_DONE;     // RELEASE (else STRETCH)
            ST_DONE:   state_nx = ST_IDLE;                     // RETIRE
            default:   state_nx = ST_IDLE;
        endcase
    end

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q      <= 1'b0;
            sel_q     <= '0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (accept) begin
            wr_q      <= req_write;
            sel_q     <= win_hit;
            mem_addr  <= win_ofs;
            mem_wdata <= req_wdata;
        end
    end

    // read data selection, empty byte when nothing is selected
    always_comb begin
        rd_pick = XDW_EMPTY_BYTE;
        for (int i = 0; i < NREG; i++) begin
            if (sel_q[i]) begin
                rd_pick = mem_rdata[i*BW +: BW];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if ((state == ST_ACCESS) && hold_last && !wr_q) begin
            rd_data <= rd_pick;
        end
    end

    // outputs
    always_comb begin
        core_wait = 1'b0;
        mem_sel   = '0;
        mem_we    = 1'b0;
        rd_valid  = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_ACCESS: begin
                core_wait = 1'b1;
                mem_sel   = sel_q;
                mem_we    = wr_q && hold_last && (sel_q != '0);
            end
            ST_DONE: begin
                rd_valid = !wr_q;
            end
            default: begin
            end
        endcase
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_sel)); // R8

    AST_SEL_NEEDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_sel != '0) |-> core_wait); // R8

    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (core_wait && $past(core_wait)) |-> $stable(mem_sel)); // R7

    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R9

    AST_WE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !core_wait); // R9

    AST_WE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $onehot(mem_sel)); // R11

    AST_RDV_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(core_wait) && !core_wait)); // R10

    AST_UNMAPPED_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && ($past(mem_sel) == '0)) |-> (rd_data == 8'hFF)); // R11

endmodule

// File: tb/sim_xdata_stretch_ctrl.sv
module sim_xdata_stretch_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_indirect;
    logic [15:0] req_ptr;
    logic [7:0]  req_lo, page_hi, req_wdata;
    logic [2:0]  stretch_sel;
    logic        core_wait, rd_valid, mem_we;
    logic [7:0]  rd_data, mem_wdata;
    logic [2:0]  mem_sel;
    logic [10:0] mem_addr;
    logic [23:0] mem_rdata;

    int total = 0;
    int fails = 0;
    int cyc   = 0;
    bit ended = 1'b0;

    // bench memories and their reference shadows
    logic [7:0] dmem [2048];
    logic [7:0] cmem [512];
    logic [7:0] imem [256];
    logic [7:0] dref [2048];
    logic [7:0] cref [512];
    logic [7:0] iref [256];

    always #4 clk = ~clk;

    xdata_stretch_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_indirect(req_indirect), .req_ptr(req_ptr), .req_lo(req_lo),
        .page_hi(page_hi), .req_wdata(req_wdata), .stretch_sel(stretch_sel),
        .core_wait(core_wait), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = {imem[mem_addr[7:0]], cmem[mem_addr[8:0]], dmem[mem_addr]};

    always @(posedge clk) begin
        if (mem_we) begin
            if (mem_sel[0]) dmem[mem_addr]      <= mem_wdata;
            if (mem_sel[1]) cmem[mem_addr[8:0]] <= mem_wdata;
            if (mem_sel[2]) imem[mem_addr[7:0]] <= mem_wdata;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 60000 && !ended) begin
            ended = 1'b1;
            total++;
            fails++;
            $display("FAIL R5 watchdog: actual %0d cycles expected completion", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int window_of(input logic [15:0] a);
        if (a <= 16'h07FF) return 0;
        if (a >= 16'h1000 && a <= 16'h11FF) return 1;
        if (a >= 16'h2000 && a <= 16'h20FF) return 2;
        return -1;
    endfunction

    function automatic int window_base(input int w);
        if (w == 1) return 'h1000;
        if (w == 2) return 'h2000;
        return 0;
    endfunction

    // one access, checked on every cycle until the sequencer is idle again
    task automatic access(input string lbl, input bit wr, input bit ind,
                          input logic [15:0] ptr, input logic [7:0] lo,
                          input logic [7:0] hi, input logic [7:0] wd,
                          input int s, input int s_mid);
        logic [15:0] a;
        int w, ofs, fw, h, exp_sel, exp_rd;
        string atag;
        a   = ind ? {hi, lo} : ptr;
        w   = window_of(a);
        ofs = (w >= 0) ? (int'(a) - window_base(w)) : 0;
        fw  = (w == 1) ? 6 : 0;
        h   = 1 + ((s > fw) ? s : fw);
        exp_sel = (w >= 0) ? (1 << w) : 0;
        atag = (w == 0) ? "R2" : (w == 1) ? "R3" : (w == 2) ? "R4" : "R11";
        if (w == 0)      exp_rd = int'(dref[ofs]);
        else if (w == 1) exp_rd = int'(cref[ofs]);
        else if (w == 2) exp_rd = int'(iref[ofs]);
        else             exp_rd = 'hFF;

        req_valid = 1'b1; req_write = wr; req_indirect = ind;
        req_ptr = ptr; req_lo = lo; page_hi = hi; req_wdata = wd;
        stretch_sel = 3'(s);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_ptr = ~ptr; req_lo = ~lo; page_hi = ~hi; req_wdata = ~wd;
        if (s_mid >= 0) stretch_sel = 3'(s_mid);
        for (int k = 1; k <= h; k++) begin
            chk("R5", {lbl, " wait high"}, int'(core_wait), 1);
            chk((w < 0) ? "R11" : "R8", {lbl, " select"}, int'(mem_sel), exp_sel);
            if (w >= 0) chk(atag, {lbl, " offset"}, int'(mem_addr), ofs);
            chk((w < 0) ? "R11" : "R9", {lbl, " write strobe"}, int'(mem_we),
                (wr && w >= 0 && k == h) ? 1 : 0);
            if (wr && w >= 0 && k == h) chk("R9", {lbl, " write data"}, int'(mem_wdata), int'(wd));
            @(negedge clk);
        end
        chk("R5", {lbl, " wait released"}, int'(core_wait), 0);
        chk("R10", {lbl, " read valid"}, int'(rd_valid), wr ? 0 : 1);
        chk("R8", {lbl, " select dropped"}, int'(mem_sel), 0);
        if (!wr) chk((w < 0) ? "R11" : "R10", {lbl, " read data"}, int'(rd_data), exp_rd);
        if (wr && w == 0) dref[ofs] = wd;
        if (wr && w == 1) cref[ofs] = wd;
        if (wr && w == 2) iref[ofs] = wd;
        @(negedge clk);
        chk("R10", {lbl, " idle valid low"}, int'(rd_valid), 0);
        chk("R5", {lbl, " idle wait low"}, int'(core_wait), 0);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) begin dmem[i] = 8'(i * 7 + 1); dref[i] = 8'(i * 7 + 1); end
        for (int i = 0; i < 512; i++)  begin cmem[i] = 8'(i * 5 + 3); cref[i] = 8'(i * 5 + 3); end
        for (int i = 0; i < 256; i++)  begin imem[i] = 8'(i * 3 + 9); iref[i] = 8'(i * 3 + 9); end
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_indirect = 1'b0;
        req_ptr = '0; req_lo = '0; page_hi = '0; req_wdata = '0; stretch_sel = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5", "reset wait", int'(core_wait), 0);
        chk("R8", "reset select", int'(mem_sel), 0);
        chk("R9", "reset strobe", int'(mem_we), 0);
        chk("R10", "reset valid", int'(rd_valid), 0);
        chk("R10", "reset data", int'(rd_data), 0);

        // data window, pointer form
        access("R2 ptr write low", 1, 0, 16'h0000, 8'h55, 8'h20, 8'hA5, 0, -1);
        access("R2 ptr read low", 0, 0, 16'h0000, 8'h00, 8'h00, 8'h00, 2, -1);
        access("R2 ptr write top", 1, 0, 16'h07FF, 8'h00, 8'h10, 8'h3C, 1, -1);
        access("R2 ptr read top", 0, 0, 16'h07FF, 8'h00, 8'h00, 8'h00, 0, -1);
        access("R2 ptr read mid", 0, 0, 16'h0456, 8'h00, 8'h00, 8'h00, 3, -1);
        // config window, indirect form, fixed wait dominates small stretch
        access("R1 R3 ind write", 1, 1, 16'h2010, 8'h34, 8'h10, 8'h77, 0, -1);
        access("R1 R3 ind read", 0, 1, 16'h0001, 8'h34, 8'h10, 8'h00, 2, -1);
        access("R3 ptr read last", 0, 0, 16'h11FF, 8'h00, 8'h00, 8'h00, 0, -1);
        access("R6 R3 cfg stretch7", 0, 0, 16'h1000, 8'h00, 8'h00, 8'h00, 7, -1);
        access("R6 data stretch7", 0, 0, 16'h0123, 8'h00, 8'h00, 8'h00, 7, -1);
        // I/O window
        access("R1 R4 ind write", 1, 1, 16'h1000, 8'hAB, 8'h20, 8'hC3, 3, -1);
        access("R1 R4 ind read", 0, 1, 16'h07FF, 8'hAB, 8'h20, 8'h00, 0, -1);
        access("R4 ptr read top", 0, 0, 16'h20FF, 8'h00, 8'h00, 8'h00, 1, -1);
        // pointer form ignores the byte ports
        access("R1 ptr vs bytes", 0, 0, 16'h2001, 8'h00, 8'h10, 8'h00, 0, -1);
        // unmapped
        access("R11 read gap", 0, 0, 16'h0800, 8'h00, 8'h00, 8'h00, 1, -1);
        access("R11 read past cfg", 0, 0, 16'h1200, 8'h00, 8'h00, 8'h00, 0, -1);
        access("R11 read past io", 0, 1, 16'h0000, 8'h00, 8'h21, 8'h00, 4, -1);
        access("R11 read ffff", 0, 0, 16'hFFFF, 8'h00, 8'h00, 8'h00, 7, -1);
        access("R11 write gap", 1, 0, 16'h0FFF, 8'h00, 8'h00, 8'hEE, 2, -1);
        access("R11 write high", 1, 0, 16'h3000, 8'h00, 8'h00, 8'hEE, 0, -1);
        // stretch changed while an access runs
        access("R7 data 1 then 7", 0, 0, 16'h0010, 8'h00, 8'h00, 8'h00, 1, 7);
        access("R7 cfg 7 then 0", 0, 0, 16'h1040, 8'h00, 8'h00, 8'h00, 7, 0);
        access("R7 io write 0 then 5", 1, 0, 16'h2080, 8'h00, 8'h00, 8'h19, 0, 5);
        access("R7 io readback", 0, 0, 16'h2080, 8'h00, 8'h00, 8'h00, 2, -1);
        // dropped writes did not land anywhere
        access("R11 data intact", 0, 0, 16'h07FF, 8'h00, 8'h00, 8'h00, 0, -1);

        ended = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule